// File: doc/BRIEF.md
# Raster-Operation Blit Pixel Datapath

This block is the per-pixel arithmetic stage of a 2D blit engine. A surrounding engine generates addresses, reads memory and clips rectangles; this block receives pixel words on a valid/ready stream and returns result pixels on a second valid/ready stream. In the two-operand modes it combines a primary operand with a destination pixel through one of sixteen bitwise boolean functions. The primary operand is the source pixel for write and move blits, and the pattern pixel for pattern fills.

A third mode turns monochrome bytes into colour pixels. Each set bit becomes the foreground colour and each clear bit becomes the background colour. In that mode the same 4-bit code that selects the boolean function instead points to the first bit to expand. Pixels are 8 or 16 bits wide, chosen per operation. An operation starts with a one-cycle start strobe that captures all configuration, runs for a programmed number of output pixels, and ends with a one-cycle done pulse.

Top module: `rop_blit_path`

## Requirements
- R1: In two-operand modes, each result bit equals bit {A,D} of the 4-bit code, where A is the primary operand bit and D is the destination bit. So 0000 gives all zeros, 1111 all ones, 1100 gives A, 1010 gives D, 0110 gives A xor D, 1000 gives A and D, 0001 gives A nor D, 0111 gives A nand D, 1001 gives A xnor D, 0011 gives not A, 0101 gives not D, 0010 gives not-A and D, 0100 gives A and not-D, 1011 gives not-A or D, 1101 gives A or not-D, and 1110 gives A or D.
- R2: Mode 00 (blit) uses the source pixel as A. Mode 01 (pattern fill) uses the pattern pixel as A. Mode 10 is colour expansion.
- R3: When the width bit is 1, results are 16 bits wide. When it is 0, only the low 8 bits are produced: the upper 8 output bits are zero and the upper input and colour bits are ignored.
- R4: In expansion mode, a set bit outputs the foreground colour and a clear bit outputs the background colour. Each bit yields one output pixel, taken LSB first. Bits run from the start bit to bit 7 of the first byte, which arrives in the low 8 bits of the source pixel, and then through bits 0 to 7 of each later byte. Bits left over in the last byte are discarded once the pixel count is reached.
- R5: In expansion mode, the start bit is code[2:0], and code[3] has no effect.
- R6: While the output is valid and not ready, the output pixel stays stable. Under backpressure, every result appears exactly once and in order.
- R7: Code, mode, width and colours are captured on the start strobe. Later changes to them, and start strobes while busy, have no effect on the running operation.
- R8: Done is a one-cycle pulse in the cycle after the final output handshake, and busy is low in that cycle. A start with a pixel count of 0 gives done in the next cycle with no output.
- R9: A start with the reserved bit set, or with mode 11, produces a one-cycle configuration-error pulse in the next cycle and starts no operation.
- R10: After reset, busy, done, the error flag, in_ready and out_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; captures configuration when idle |
| cfg_code | input | 4 | Boolean function code or expansion start bit |
| cfg_mode | input | 2 | 00 blit, 01 pattern fill, 10 colour expand, 11 invalid |
| cfg_wide | input | 1 | 1 = 16-bit pixels, 0 = 8-bit pixels |
| cfg_rsvd | input | 1 | Reserved; must be 0 |
| cfg_count | input | 16 | Number of output pixels |
| fg_color | input | 16 | Foreground colour for expansion |
| bg_color | input | 16 | Background colour for expansion |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| src_pix | input | 16 | Source pixel, or monochrome byte in bits 7:0 |
| pat_pix | input | 16 | Pattern pixel |
| dst_pix | input | 16 | Destination pixel |
| out_valid | output | 1 | Result pixel valid |
| out_ready | input | 1 | Downstream accepts result |
| out_pix | output | 16 | Result pixel |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| cfg_err | output | 1 | One-cycle configuration error pulse |

## Verification
The assertions check on every cycle that a stalled output holds its value, that narrow results keep their upper byte at zero, and that expansion outputs only ever carry one of the two captured colours. They also check that captured configuration stays fixed while busy, and that done and error pulses only occur while idle. Several behaviours can only be shown by the bench's scenarios, because they depend on the whole sequence of words: that every code maps to the right boolean function, that the pattern operand replaces the source in fills, that expansion begins at the right bit and walks LSB first across byte boundaries, and that no pixel is lost or repeated under irregular backpressure.

// File: rtl/rop_blit_pkg.sv
package rop_blit_pkg;
  localparam int CODE_W  = 4;
  localparam int MONO_W  = 8;
  localparam int BIDX_W  = $clog2(MONO_W);

  typedef enum logic [1:0] {
    MODE_BLIT   = 2'b00,
    MODE_FILL   = 2'b01,
    MODE_EXPAND = 2'b10,
    MODE_BAD    = 2'b11
  } blit_mode_e;
endpackage

// File: rtl/rop_blit_func.sv
// Bitwise two-operand boolean function selected by a truth-table code.
module rop_blit_func #(
  parameter int W = 16
) (
  input  logic [3:0]   code,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opd,
  output logic [W-1:0] res
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // The code is the truth table; operand bits form its index.
    assign res[i] = code[{opa[i], opd[i]}];
  end
endmodule

// File: rtl/rop_blit_mono.sv
// Picks foreground or background colour from one bit of a mono byte.
module rop_blit_mono
  import rop_blit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [MONO_W-1:0] mono,
  input  logic [BIDX_W-1:0] idx,
  input  logic [W-1:0]      fg,
  input  logic [W-1:0]      bg,
  output logic [W-1:0]      pix
);
  always_comb begin
    pix = mono[idx] ? fg : bg;
  end
endmodule

// File: rtl/rop_blit_path.sv
module rop_blit_path
  import rop_blit_pkg::*;
#(
  parameter int PIX_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       cfg_code,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_wide,
  input  logic             cfg_rsvd,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [PIX_W-1:0] fg_color,
  input  logic [PIX_W-1:0] bg_color,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] src_pix,
  input  logic [PIX_W-1:0] pat_pix,
  input  logic [PIX_W-1:0] dst_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix,
  output logic             busy,
  output logic             done,
  output logic             cfg_err
);
  localparam int HALF_W = PIX_W / 2;
  localparam logic [PIX_W-1:0] NARROW_MASK = {{(PIX_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [PIX_W-1:0] WIDE_MASK   = {PIX_W{1'b1}};

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // State
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [3:0]        code_q, code_d;
  blit_mode_e        mode_q, mode_d;
  logic              wide_q, wide_d;
  logic [PIX_W-1:0]  fg_q, fg_d, bg_q, bg_d;
  logic [CNT_W-1:0]  rem_in_q, rem_in_d;
  logic [CNT_W-1:0]  rem_out_q, rem_out_d;
  logic [MONO_W-1:0] byte_q, byte_d;
  logic              bvld_q, bvld_d;
  logic [BIDX_W-1:0] bit_q, bit_d;
  logic              ov_q, ov_d;
  logic [PIX_W-1:0]  opix_q, opix_d;

  // Datapath
  logic             is_exp, out_free, out_fire, in_fire, gen_fire, launch, cfg_ok;
  logic [PIX_W-1:0] pix_mask, opa, rop_res, mono_res, load_pix;

  assign is_exp   = (mode_q == MODE_EXPAND);
  assign out_free = !ov_q || out_ready;
  assign out_fire = ov_q && out_ready;
  assign pix_mask = wide_q ? WIDE_MASK : NARROW_MASK;
  assign opa      = (mode_q == MODE_FILL) ? pat_pix : src_pix;
  assign launch   = start && !busy_q;
  assign cfg_ok   = !cfg_rsvd && (blit_mode_e'(cfg_mode) != MODE_BAD);

  assign in_ready = busy_q && (rem_in_q != '0) && (is_exp ? !bvld_q : out_free);
  assign in_fire  = in_valid && in_ready;
  assign gen_fire = busy_q && is_exp && bvld_q && (rem_in_q != '0) && out_free;

  rop_blit_func #(.W(PIX_W)) u_func (
    .code (code_q),
    .opa  (opa),
    .opd  (dst_pix),
    .res  (rop_res)
  );

  rop_blit_mono #(.W(PIX_W)) u_mono (
    .mono (byte_q),
    .idx  (bit_q),
    .fg   (fg_q),
    .bg   (bg_q),
    .pix  (mono_res)
  );

  assign load_pix = (is_exp ? mono_res : rop_res) & pix_mask;

  // Next state
  always_comb begin
    busy_d    = busy_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    code_d    = code_q;
    mode_d    = mode_q;
    wide_d    = wide_q;
    fg_d      = fg_q;
    bg_d      = bg_q;
    rem_in_d  = rem_in_q;
    rem_out_d = rem_out_q;
    byte_d    = byte_q;
    bvld_d    = bvld_q;
    bit_d     = bit_q;
    ov_d      = ov_q;
    opix_d    = opix_q;

    if (launch) begin
      if (!cfg_ok) begin
        err_d = 1'b1;
      end else if (cfg_count == '0) begin
        done_d = 1'b1;
      end else begin
        busy_d    = 1'b1;
        code_d    = cfg_code;
        mode_d    = blit_mode_e'(cfg_mode);
        wide_d    = cfg_wide;
        fg_d      = fg_color;
        bg_d      = bg_color;
        rem_in_d  = cfg_count;
        rem_out_d = cfg_count;
        bit_d     = cfg_code[BIDX_W-1:0];
        bvld_d    = 1'b0;
      end
    end

    if (in_fire) begin
      if (is_exp) begin
        byte_d = src_pix[MONO_W-1:0];
        bvld_d = 1'b1;
      end else begin
        rem_in_d = rem_in_q - 1'b1;
      end
    end

    if (gen_fire) begin
      rem_in_d = rem_in_q - 1'b1;
      bit_d    = bit_q + 1'b1;
      if ((bit_q == BIDX_W'(MONO_W - 1)) || (rem_in_q == CNT_W'(1)))
        bvld_d = 1'b0;
    end

    if (out_fire) begin
      rem_out_d = rem_out_q - 1'b1;
      if (rem_out_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end

    if ((in_fire && !is_exp) || gen_fire) begin
      ov_d   = 1'b1;
      opix_d = load_pix;
    end else if (out_fire) begin
      ov_d = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      code_q    <= '0;
      mode_q    <= MODE_BLIT;
      wide_q    <= 1'b0;
      fg_q      <= '0;
      bg_q      <= '0;
      rem_in_q  <= '0;
      rem_out_q <= '0;
      byte_q    <= '0;
      bvld_q    <= 1'b0;
      bit_q     <= '0;
      ov_q      <= 1'b0;
      opix_q    <= '0;
    end else begin
      busy_q    <= busy_d;
      done_q    <= done_d;
      err_q     <= err_d;
      code_q    <= code_d;
      mode_q    <= mode_d;
      wide_q    <= wide_d;
      fg_q      <= fg_d;
      bg_q      <= bg_d;
      rem_in_q  <= rem_in_d;
      rem_out_q <= rem_out_d;
      byte_q    <= byte_d;
      bvld_q    <= bvld_d;
      bit_q     <= bit_d;
      ov_q      <= ov_d;
      opix_q    <= opix_d;
    end
  end

  assign out_valid = ov_q;
  assign out_pix   = opix_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign cfg_err   = err_q;
endmodule

// File: rtl/rop_blit_chk.sv
module rop_blit_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             cfg_err,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix,
  input logic [3:0]       code_q,
  input logic [1:0]       mode_q,
  input logic             wide_q,
  input logic [PIX_W-1:0] fg_q,
  input logic [PIX_W-1:0] bg_q
);
  localparam int HALF_W = PIX_W / 2;
  logic [PIX_W-1:0] mask;
  assign mask = wide_q ? {PIX_W{1'b1}} : {{(PIX_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !wide_q |-> out_pix[PIX_W-1:HALF_W] == '0);

  a_r4_expand_two_colours: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == 2'b10 |-> (out_pix == (fg_q & mask)) || (out_pix == (bg_q & mask)));

  a_r1_code_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q != 2'b10 && code_q == 4'b0000 |-> out_pix == '0);

  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(code_q) && $stable(mode_q) && $stable(wide_q));

  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !out_valid);

  a_r9_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && !done);

  a_r10_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);
endmodule

bind rop_blit_path rop_blit_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .busy      (busy),
  .done      (done),
  .cfg_err   (cfg_err),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix),
  .code_q    (code_q),
  .mode_q    (mode_q),
  .wide_q    (wide_q),
  .fg_q      (fg_q),
  .bg_q      (bg_q)
);

// File: tb/rop_blit_path_test.sv
`timescale 1ns/1ps
module rop_blit_path_test;
  logic        clk, rst_n;
  logic        start, cfg_wide, cfg_rsvd, in_valid, out_ready;
  logic [3:0]  cfg_code;
  logic [1:0]  cfg_mode;
  logic [15:0] cfg_count, fg_color, bg_color, src_pix, pat_pix, dst_pix;
  logic        in_ready, out_valid, busy, done, cfg_err;
  logic [15:0] out_pix;

  rop_blit_path uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_code(cfg_code), .cfg_mode(cfg_mode),
    .cfg_wide(cfg_wide), .cfg_rsvd(cfg_rsvd), .cfg_count(cfg_count),
    .fg_color(fg_color), .bg_color(bg_color), .in_valid(in_valid), .in_ready(in_ready),
    .src_pix(src_pix), .pat_pix(pat_pix), .dst_pix(dst_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int          checks = 0, errors = 0;
  bit          finished = 0;
  string       cur_tag = "R1";
  logic [15:0] exp_q[$];
  bit          stall_en = 0;
  logic [7:0]  lfsr = 8'h5A;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  // Output backpressure driver
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = stall_en ? (lfsr[0] & lfsr[2]) | lfsr[5] : 1'b1;
    end
  end

  // Scoreboard monitor and hold check (R6)
  logic [15:0] held_pix;
  bit          held = 0;
  always @(negedge clk) begin
    if (held) chk(out_valid && out_pix == held_pix, "R6 hold", out_pix, held_pix);
    held = 0;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R6 extra pixel", out_pix, 16'h0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(out_pix == e, cur_tag, out_pix, e);
      end
    end else if (out_valid) begin
      held = 1;
      held_pix = out_pix;
    end
  end

  function automatic logic [15:0] rop_model(input logic [3:0] c, input logic [15:0] a,
                                            input logic [15:0] d, input logic w);
    logic [15:0] r;
    case (c)
      4'd0:  r = 16'h0000;
      4'd1:  r = ~(a | d);
      4'd2:  r = ~a & d;
      4'd3:  r = ~a;
      4'd4:  r = a & ~d;
      4'd5:  r = ~d;
      4'd6:  r = a ^ d;
      4'd7:  r = ~(a & d);
      4'd8:  r = a & d;
      4'd9:  r = ~(a ^ d);
      4'd10: r = d;
      4'd11: r = ~a | d;
      4'd12: r = a;
      4'd13: r = a | ~d;
      4'd14: r = a | d;
      default: r = 16'hFFFF;
    endcase
    return w ? r : {8'h00, r[7:0]};
  endfunction

  task automatic begin_op(input logic [1:0] m, input logic [3:0] c, input logic w,
                          input logic rsv, input logic [15:0] n);
    @(posedge clk); #1;
    start = 1; cfg_mode = m; cfg_code = c; cfg_wide = w; cfg_rsvd = rsv; cfg_count = n;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic send(input logic [15:0] s, input logic [15:0] p, input logic [15:0] d);
    src_pix = s; pat_pix = p; dst_pix = d; in_valid = 1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic wait_done(input string tag);
    int k;
    for (k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(done == 1'b1, {tag, " R8 done"}, 16'(done), 16'h1);
    chk(busy == 1'b0, {tag, " R8 busy low at done"}, 16'(busy), 16'h0);
    chk(exp_q.size() == 0, {tag, " R6 all pixels out"}, 16'(exp_q.size()), 16'h0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 done one cycle"}, 16'(done), 16'h0);
  endtask

  task automatic blit_op(input logic [1:0] m, input logic [3:0] c, input logic w,
                         input int n, input logic [15:0] seed, input string tag);
    logic [15:0] s[32], p[32], d[32];
    cur_tag = tag;
    for (int k = 0; k < n; k++) begin
      s[k] = seed * 16'h9E37 + 16'(k) * 16'h3C1B;
      p[k] = seed ^ (16'(k) * 16'h7A55) ^ 16'hA0F3;
      d[k] = (seed + 16'h1357) * 16'(k + 3) ^ 16'h5C3A;
      exp_q.push_back(rop_model(c, (m == 2'b01) ? p[k] : s[k], d[k], w));
    end
    begin_op(m, c, w, 1'b0, 16'(n));
    for (int k = 0; k < n; k++) send(s[k], p[k], d[k]);
    wait_done(tag);
  endtask

  task automatic expand_op(input logic [3:0] c, input logic w, input int n,
                           input logic [31:0] bytes, input string tag);
    int idx, bi, used;
    logic [15:0] msk;
    cur_tag = tag;
    msk = w ? 16'hFFFF : 16'h00FF;
    idx = int'(c[2:0]); bi = 0; used = 0;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(bytes[bi*8 + idx] ? (fg_color & msk) : (bg_color & msk));
      used = bi + 1;
      idx++;
      if (idx == 8) begin idx = 0; bi++; end
    end
    begin_op(2'b10, c, w, 1'b0, 16'(n));
    for (int b = 0; b < used; b++) send({8'hEE, bytes[b*8 +: 8]}, 16'h0, 16'h0);
    wait_done(tag);
  endtask

  initial begin
    rst_n = 0; start = 0; cfg_code = 0; cfg_mode = 0; cfg_wide = 1; cfg_rsvd = 0;
    cfg_count = 0; fg_color = 16'hC3A5; bg_color = 16'h1E2F;
    in_valid = 0; src_pix = 0; pat_pix = 0; dst_pix = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(busy == 0, "R10 busy", 16'(busy), 16'h0);
    chk(done == 0, "R10 done", 16'(done), 16'h0);
    chk(cfg_err == 0, "R10 cfg_err", 16'(cfg_err), 16'h0);
    chk(in_ready == 0, "R10 in_ready", 16'(in_ready), 16'h0);
    chk(out_valid == 0, "R10 out_valid", 16'(out_valid), 16'h0);

    // R1 all sixteen codes, blit mode, 16-bit
    for (int c = 0; c < 16; c++) blit_op(2'b00, 4'(c), 1'b1, 3, 16'(c * 37 + 5), "R1 blit code");
    // R2 pattern fill uses P
    blit_op(2'b01, 4'hC, 1'b1, 4, 16'h2468, "R2 fill P");
    blit_op(2'b01, 4'h6, 1'b1, 4, 16'h1111, "R2 fill P^D");
    blit_op(2'b01, 4'hB, 1'b1, 3, 16'h0F0F, "R2 fill ~P|D");
    // R3 narrow pixels
    blit_op(2'b00, 4'hE, 1'b0, 5, 16'hF1E2, "R3 narrow S|D");
    blit_op(2'b00, 4'h3, 1'b0, 3, 16'h8001, "R3 narrow ~S");
    // R6 backpressure
    stall_en = 1;
    blit_op(2'b00, 4'h9, 1'b1, 24, 16'h7777, "R6 stalled xnor");
    blit_op(2'b01, 4'hD, 1'b0, 12, 16'h3141, "R6 stalled fill narrow");
    stall_en = 0;

    // R4 / R5 colour expansion
    expand_op(4'h5, 1'b1, 15, 32'h00963CA5, "R4 expand start5");
    expand_op(4'h0, 1'b1, 16, 32'h0000F00F, "R4 expand two bytes");
    expand_op(4'hD, 1'b1, 15, 32'h00963CA5, "R5 code3 ignored");
    expand_op(4'h7, 1'b0, 10, 32'h00005A81, "R3 R4 expand narrow");
    stall_en = 1;
    expand_op(4'h2, 1'b1, 22, 32'h00C3691B, "R6 expand stalled");
    stall_en = 0;

    // R7 config changes and restarts while busy are ignored
    cur_tag = "R7 latched config";
    exp_q.push_back(rop_model(4'hC, 16'hAAAA, 16'h0F0F, 1'b1));
    exp_q.push_back(rop_model(4'hC, 16'h1234, 16'hFFFF, 1'b1));
    exp_q.push_back(rop_model(4'hC, 16'h8421, 16'h0000, 1'b1));
    begin_op(2'b00, 4'hC, 1'b1, 1'b0, 16'd3);
    cfg_code = 4'h3; cfg_mode = 2'b01; cfg_wide = 1'b0;
    send(16'hAAAA, 16'h5555, 16'h0F0F);
    start = 1; cfg_count = 16'd1;
    @(posedge clk); #1 start = 0;
    send(16'h1234, 16'h0000, 16'hFFFF);
    send(16'h8421, 16'h0000, 16'h0000);
    wait_done("R7");
    repeat (3) @(negedge clk);
    chk(busy == 0 && out_valid == 0, "R7 restart ignored", {14'h0, busy, out_valid}, 16'h0);

    // R8 zero count
    begin_op(2'b00, 4'h6, 1'b1, 1'b0, 16'd0);
    @(negedge clk);
    chk(done == 1 && busy == 0, "R8 zero count done", {14'h0, done, busy}, 16'h2);
    @(negedge clk);
    chk(done == 0 && out_valid == 0, "R8 zero count quiet", {14'h0, done, out_valid}, 16'h0);

    // R9 reserved bit and bad mode
    begin_op(2'b00, 4'h6, 1'b1, 1'b1, 16'd4);
    @(negedge clk);
    chk(cfg_err == 1 && busy == 0, "R9 reserved bit", {14'h0, cfg_err, busy}, 16'h2);
    @(negedge clk);
    chk(cfg_err == 0 && in_ready == 0, "R9 pulse ends", {14'h0, cfg_err, in_ready}, 16'h0);
    begin_op(2'b11, 4'h6, 1'b1, 1'b0, 16'd4);
    @(negedge clk);
    chk(cfg_err == 1 && busy == 0, "R9 bad mode", {14'h0, cfg_err, busy}, 16'h2);
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && busy == 0, "R9 nothing started", {14'h0, out_valid, busy}, 16'h0);

    report();
  end
endmodule